// File: doc/BRIEF.md
# Chained-Group Instruction Dispatcher with Guarded Issue

This block sits between instruction fetch and the functional units of a wide-issue core. It accepts one fetch packet at a time, holding a fixed number of fixed-width instruction words. A marker bit in each word cuts the packet into parallel groups. The block issues one whole group per clock cycle and routes every word to the functional-unit slot its unit field names.

Each word also carries a guard: a condition-register select plus an invert flag. The guard is evaluated in the cycle the group issues. A word whose guard fails still occupies its slot, but it is presented as a squashed no-op and does not fire. This lets one group carry both arms of an if/else.

Words that name the same unit within one group form an illegal encoding. The block flags such a group and issues none of it. A new packet is accepted only after the final group of the current one has gone out.

Top module: `vliw_group_dispatch`

## Requirements
- R1: After reset, `pkt_ready` is 1. `slot_fire`, `slot_squash`, `fetch_req` and `enc_err` are all 0.
- R2: A packet is taken on a clock edge where `pkt_valid` and `pkt_ready` are both 1. From the next cycle, `pkt_ready` stays 0 until the cycle after the packet's final group has issued. While it is 0, `pkt_valid` and `pkt_data` have no effect.
- R3: Bit 0 of each word is the chaining bit: 1 means the group continues with the next word, 0 means the group ends at this word. Lane 0 occupies `pkt_data[31:0]`. The first group issues in the cycle after acceptance. Each following group issues in the next cycle, and all words of one group appear in the same cycle.
- R4: The word in the last lane always closes its group, even when its chaining bit is 1.
- R5: Bits 2:1 of a word select the functional-unit slot it issues on. `slot_word[u*32 +: 32]` shows the full word routed to slot u whenever that slot fires or is squashed.
- R6: Bits 31:29 of a word select a condition register, and bit 28 inverts it. Select 0 means unconditional: the word always fires and bit 28 is ignored. For any other select s, the guard is `pred_regs[s]` XOR bit 28. If the guard is 1 the slot's `slot_fire` bit is set; if it is 0 the slot's `slot_squash` bit is set instead.
- R7: The guard uses the `pred_regs` value present in the issue cycle itself. A change between groups of one packet affects the later groups. `pred_regs[0]` has no effect.
- R8: If two words of one group name the same slot, `enc_err` is 1 in that group's cycle and `slot_fire` and `slot_squash` are both all-zero. Words with a failing guard count toward this conflict. Issue then carries on with the next group.
- R9: `fetch_req` is 1 exactly in the cycle the final group of a packet issues. `pkt_ready` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Fetch packet offered |
| pkt_data | input | 256 | Eight 32-bit words, lane 0 in the low bits |
| pkt_ready | output | 1 | Block can take a packet |
| pred_regs | input | 8 | Condition register values, bit s is register s |
| slot_fire | output | 4 | Per slot: a word issues with a true guard |
| slot_squash | output | 4 | Per slot: a word occupies the slot as a no-op |
| slot_word | output | 128 | Word routed to each slot, slot u at bits u*32+31:u*32 |
| fetch_req | output | 1 | Final group of the packet issues this cycle |
| enc_err | output | 1 | Current group has a slot conflict |

## Verification
A wrong group cursor shows up in the very next issue cycle. The wrong words appear on the slots, or a group is split or merged, and from then on the count of cycles up to `fetch_req` is off. A wrong phase bit shows up at once: `pkt_ready` is high while slots issue, or low while nothing is pending. A guard or conflict fault is purely combinational in the issue cycle, so it shows on `slot_fire`, `slot_squash` or `enc_err` in that same cycle.

// File: rtl/vgd_pkg.sv
package vgd_pkg;
    // bit positions inside an instruction word
    localparam int CHAIN_BIT    = 0;
    localparam int UNIT_LSB     = 1;
    localparam int GUARD_INV    = 28;
    localparam int GUARD_SEL_LO = 29;
    localparam int GUARD_SEL_W  = 3;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ISSUE = 1'b1
    } phase_e;
endpackage

// File: rtl/vgd_group_finder.sv
module vgd_group_finder #(
    parameter int LANES = 8,
    parameter int CW    = $clog2(LANES)
) (
    input  logic [LANES-1:0] chain,
    input  logic [CW-1:0]    cursor,
    output logic [LANES-1:0] member,
    output logic [CW-1:0]    last_lane,
    output logic             is_final
);
    always_comb begin
        logic open;
        logic done;
        open      = 1'b0;
        done      = 1'b0;
        member    = '0;
        last_lane = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!done && CW'(i) == cursor) open = 1'b1;
            if (open) begin
                member[i] = 1'b1;
                if (!chain[i] || i == LANES - 1) begin
                    last_lane = CW'(i);
                    open      = 1'b0;
                    done      = 1'b1;
                end
            end
        end
        is_final = (last_lane == CW'(LANES - 1));
    end
endmodule

// File: rtl/vgd_pred_eval.sv
module vgd_pred_eval #(
    parameter int LANES = 8,
    parameter int IW    = 32,
    parameter int PREGS = 8
) (
    input  logic [LANES*IW-1:0] words,
    input  logic [PREGS-1:0]    pregs,
    output logic [LANES-1:0]    pass
);
    import vgd_pkg::*;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [GUARD_SEL_W-1:0] sel;
        logic                   inv;
        assign sel = words[g*IW + GUARD_SEL_LO +: GUARD_SEL_W];
        assign inv = words[g*IW + GUARD_INV];
        always_comb begin
            if (sel == '0) pass[g] = 1'b1;
            else           pass[g] = pregs[sel] ^ inv;
        end
    end
endmodule

// File: rtl/vgd_slot_router.sv
module vgd_slot_router #(
    parameter int LANES = 8,
    parameter int IW    = 32,
    parameter int UNITS = 4,
    parameter int UW    = $clog2(UNITS)
) (
    input  logic [LANES*IW-1:0] words,
    input  logic [LANES-1:0]    member,
    input  logic [LANES-1:0]    pass,
    output logic [UNITS-1:0]    fire,
    output logic [UNITS-1:0]    squash,
    output logic [UNITS*IW-1:0] routed,
    output logic                conflict
);
    import vgd_pkg::*;

    localparam int NW = $clog2(LANES + 1);

    logic [UNITS-1:0] hit;
    logic [UNITS-1:0] multi;
    logic [UNITS-1:0] good;

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        always_comb begin
            logic [NW-1:0] cnt;
            cnt                 = '0;
            good[u]             = 1'b0;
            routed[u*IW +: IW]  = '0;
            for (int l = 0; l < LANES; l++) begin
                if (member[l] && words[l*IW + UNIT_LSB +: UW] == UW'(u)) begin
                    cnt                = cnt + NW'(1);
                    good[u]            = pass[l];
                    routed[u*IW +: IW] = words[l*IW +: IW];
                end
            end
            hit[u]   = (cnt != '0);
            multi[u] = (cnt > NW'(1));
        end
    end

    assign conflict = |multi;
    assign fire     = conflict ? '0 : (hit & good);
    assign squash   = conflict ? '0 : (hit & ~good);
endmodule

// File: rtl/vliw_group_dispatch.sv
module vliw_group_dispatch #(
    parameter int LANES = 8,
    parameter int IW    = 32,
    parameter int UNITS = 4,
    parameter int PREGS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pkt_valid,
    input  logic [LANES*IW-1:0] pkt_data,
    output logic                pkt_ready,
    input  logic [PREGS-1:0]    pred_regs,
    output logic [UNITS-1:0]    slot_fire,
    output logic [UNITS-1:0]    slot_squash,
    output logic [UNITS*IW-1:0] slot_word,
    output logic                fetch_req,
    output logic                enc_err
);
    import vgd_pkg::*;

    localparam int CW = $clog2(LANES);

    typedef struct packed {
        phase_e             phase;
        logic [CW-1:0]      cursor;
        logic [LANES*IW-1:0] pkt;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0] chain;
    logic [LANES-1:0] member;
    logic [LANES-1:0] pass;
    logic [CW-1:0]    last_lane;
    logic             is_final;
    logic [UNITS-1:0] fire_raw, squash_raw;
    logic             conflict;
    logic             issuing;

    for (genvar g = 0; g < LANES; g++) begin : g_chain
        assign chain[g] = st_q.pkt[g*IW + CHAIN_BIT];
    end

    vgd_group_finder #(.LANES(LANES), .CW(CW)) finder_i (
        .chain     (chain),
        .cursor    (st_q.cursor),
        .member    (member),
        .last_lane (last_lane),
        .is_final  (is_final)
    );

    vgd_pred_eval #(.LANES(LANES), .IW(IW), .PREGS(PREGS)) guard_i (
        .words (st_q.pkt),
        .pregs (pred_regs),
        .pass  (pass)
    );

    vgd_slot_router #(.LANES(LANES), .IW(IW), .UNITS(UNITS)) router_i (
        .words    (st_q.pkt),
        .member   (member),
        .pass     (pass),
        .fire     (fire_raw),
        .squash   (squash_raw),
        .routed   (slot_word),
        .conflict (conflict)
    );

    assign issuing     = (st_q.phase == PH_ISSUE);
    assign pkt_ready   = !issuing;
    assign slot_fire   = issuing ? fire_raw   : '0;
    assign slot_squash = issuing ? squash_raw : '0;
    assign fetch_req   = issuing && is_final;
    assign enc_err     = issuing && conflict;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (pkt_valid) begin
                    st_d.pkt    = pkt_data;
                    st_d.cursor = '0;
                    st_d.phase  = PH_ISSUE;
                end
            end
            PH_ISSUE: begin
                if (is_final) st_d.phase  = PH_IDLE;
                else          st_d.cursor = last_lane + CW'(1);
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.cursor <= '0;
            st_q.pkt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/vgd_dispatch_chk.sv
module vgd_dispatch_chk #(
    parameter int UNITS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic             pkt_ready,
    input logic [UNITS-1:0] slot_fire,
    input logic [UNITS-1:0] slot_squash,
    input logic             fetch_req,
    input logic             enc_err
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (slot_fire == '0 && slot_squash == '0 && !fetch_req && !enc_err));
    // R2
    accept_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> !pkt_ready);
    // R2
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_ready && !fetch_req) |=> !pkt_ready);
    // R9
    final_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> pkt_ready);
    // R8
    conflict_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_err |-> (slot_fire == '0 && slot_squash == '0));
    // R6
    fire_squash_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_fire & slot_squash) == '0);
endmodule

bind vliw_group_dispatch vgd_dispatch_chk #(.UNITS(UNITS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_valid   (pkt_valid),
    .pkt_ready   (pkt_ready),
    .slot_fire   (slot_fire),
    .slot_squash (slot_squash),
    .fetch_req   (fetch_req),
    .enc_err     (enc_err)
);

// File: tb/vliw_group_dispatch_tb_top.sv
module vliw_group_dispatch_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pkt_valid = 1'b0;
    logic [255:0] pkt_data = '0;
    logic         pkt_ready;
    logic [7:0]   pred_regs = '0;
    logic [3:0]   slot_fire, slot_squash;
    logic [127:0] slot_word;
    logic         fetch_req, enc_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] ln [8];

    always #2 clk = ~clk;

    vliw_group_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_ready(pkt_ready), .pred_regs(pred_regs), .slot_fire(slot_fire),
        .slot_squash(slot_squash), .slot_word(slot_word),
        .fetch_req(fetch_req), .enc_err(enc_err)
    );

    function automatic logic [31:0] mk(int id, int u, int c, int sel, int inv);
        return {3'(sel), 1'(inv), 19'h0, 6'(id), 2'(u), 1'(c)};
    endfunction

    function automatic logic [255:0] packed_lanes();
        logic [255:0] p;
        for (int i = 0; i < 8; i++) p[i*32 +: 32] = ln[i];
        return p;
    endfunction

    task automatic send();
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_data  = packed_lanes();
        @(posedge clk);
        #1;
        pkt_valid = 1'b0;
    endtask

    // check the current cycle, then advance to just after the next edge
    task automatic chk(input logic [3:0] ef, input logic [3:0] es, input logic ee,
                       input logic efq, input logic erdy, input string tag);
        logic [10:0] act, exp;
        #1;
        act = {slot_fire, slot_squash, enc_err, fetch_req, pkt_ready};
        exp = {ef, es, ee, efq, erdy};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: fire/squash/err/freq/rdy act=%b_%b_%b_%b_%b exp=%b_%b_%b_%b_%b",
                     tag, act[10:7], act[6:3], act[2], act[1], act[0],
                     exp[10:7], exp[6:3], exp[2], exp[1], exp[0]);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic chk_word(input int u, input logic [31:0] ew, input string tag);
        n_chk++;
        if (slot_word[u*32 +: 32] !== ew) begin
            n_bad++;
            $display("FAIL %s: slot%0d word act=%h exp=%h", tag, u, slot_word[u*32 +: 32], ew);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, "R1 reset");
    endtask

    task automatic t_groups();
        pred_regs = 8'h00;
        ln[0] = mk(1, 0, 0, 0, 0);
        ln[1] = mk(2, 0, 1, 0, 0);
        ln[2] = mk(3, 1, 1, 0, 0);
        ln[3] = mk(4, 2, 0, 0, 0);
        ln[4] = mk(5, 1, 1, 0, 0);
        ln[5] = mk(6, 2, 1, 0, 0);
        ln[6] = mk(7, 3, 0, 0, 0);
        ln[7] = mk(8, 3, 1, 0, 0);
        send();
        chk_word(0, ln[0], "R5 g0 slot0");
        chk(4'b0001, 4'b0000, 1'b0, 1'b0, 1'b0, "R3 group of 1");
        chk_word(1, ln[2], "R5 g1 slot1");
        chk_word(0, ln[1], "R5 g1 slot0");
        chk(4'b0111, 4'b0000, 1'b0, 1'b0, 1'b0, "R3 group of 3 first");
        chk(4'b1110, 4'b0000, 1'b0, 1'b0, 1'b0, "R3 group of 3 second");
        chk_word(3, ln[7], "R4 last lane slot3");
        chk(4'b1000, 4'b0000, 1'b0, 1'b1, 1'b0, "R4 R9 last lane closes");
        chk(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, "R9 ready returns");
    endtask

    task automatic t_guard();
        // regs: r1=1, r2=0, r3=0; bit 0 set but must be ignored
        pred_regs = 8'b0000_0011;
        ln[0] = mk(10, 0, 1, 1, 0);
        ln[1] = mk(11, 1, 1, 1, 1);
        ln[2] = mk(12, 2, 1, 2, 0);
        ln[3] = mk(13, 3, 0, 0, 1);
        for (int i = 4; i < 8; i++) ln[i] = mk(14 + i, 0, 0, 3, 0);
        send();
        chk_word(1, ln[1], "R5 squashed word visible");
        chk(4'b1001, 4'b0110, 1'b0, 1'b0, 1'b0, "R6 true/inverted/unconditional");
        chk(4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0, "R7 r3 clear squashes");
        pred_regs = 8'b0000_1010;
        chk(4'b0001, 4'b0000, 1'b0, 1'b0, 1'b0, "R7 r3 set in issue cycle fires");
        pred_regs = 8'b0000_0011;
        chk(4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0, "R7 r3 cleared again");
        pred_regs = 8'b0000_1000;
        chk(4'b0001, 4'b0000, 1'b0, 1'b1, 1'b0, "R7 final group guard");
        chk(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, "R9 idle after guard packet");
    endtask

    task automatic t_conflict();
        pred_regs = 8'b0000_0010;  // r2 = 0
        ln[0] = mk(20, 1, 1, 1, 0);
        ln[1] = mk(21, 1, 0, 2, 0);  // false guard, same slot
        ln[2] = mk(22, 2, 0, 0, 0);
        ln[3] = mk(23, 0, 1, 0, 0);
        ln[4] = mk(24, 1, 1, 0, 0);
        ln[5] = mk(25, 2, 1, 0, 0);
        ln[6] = mk(26, 3, 0, 0, 0);
        ln[7] = mk(27, 0, 0, 0, 0);
        send();
        chk(4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, "R8 conflict with squashed word");
        chk(4'b0100, 4'b0000, 1'b0, 1'b0, 1'b0, "R8 next group continues");
        chk_word(2, ln[5], "R5 full group slot2");
        chk(4'b1111, 4'b0000, 1'b0, 1'b0, 1'b0, "R5 four slots at once");
        chk(4'b0001, 4'b0000, 1'b0, 1'b1, 1'b0, "R9 final after conflict");
        chk(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, "R9 idle after conflict packet");
    endtask

    task automatic t_busy_ignore();
        logic [255:0] pkt_b;
        pred_regs = 8'h00;
        for (int i = 0; i < 8; i++) ln[i] = mk(30 + i, i % 4, (i % 4 == 3) ? 0 : 1, 0, 0);
        send();
        for (int i = 0; i < 8; i++) pkt_b[i*32 +: 32] = mk(40 + i, 2, 0, 0, 0);
        pkt_valid = 1'b1;
        pkt_data  = pkt_b;
        chk_word(0, ln[0], "R2 first packet kept");
        chk(4'b1111, 4'b0000, 1'b0, 1'b0, 1'b0, "R2 busy group 0");
        chk_word(3, ln[7], "R2 offer ignored while busy");
        chk(4'b1111, 4'b0000, 1'b0, 1'b1, 1'b0, "R2 busy final group");
        chk(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, "R9 ready before second packet");
        pkt_valid = 1'b0;
        chk_word(2, pkt_b[31:0], "R2 second packet accepted");
        for (int i = 0; i < 8; i++)
            chk(4'b0100, 4'b0000, 1'b0, (i == 7), 1'b0, "R3 single-word groups");
        chk(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, "R9 idle at end");
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_groups();
        t_guard();
        t_conflict();
        t_busy_ignore();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule